// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes every instruction in one clock period. In one cycle it fetches the word at the program counter, splits it into fields, reads two source registers, runs the ALU, does the data-memory access and writes the result back. It supports register-register add, sub, and, or, set-less-than and their unsigned-named add/sub twins, an OR with a zero-extended immediate, word loads and stores, a conditional branch on equality and an absolute jump. Instruction and data storage are separate word-addressed arrays inside the core. The instruction array is filled through a simple write port, normally while the core is held in reset.

Every state change happens on the rising clock edge. The core reports each commit on its ports: the program counter and current instruction word, the register write-back (enable, register number, value) and the store (enable, byte address, value). A system or a bench can therefore follow execution one cycle at a time without looking inside.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter is 0 and neither `wb_en` nor `st_en` is asserted. After release, the first instruction fetched is the word at address 0.
- R2: With opcode bits [31:26] = 0x00, funct bits [5:0] select the operation on R[rs] (bits 25:21) and R[rt] (bits 20:16), and the result goes to R[rd] (bits 15:11). 0x20 and 0x21 give the sum and 0x22 and 0x23 give the difference. All four wrap modulo 2^32 and never trap. Every instruction other than beq and j advances the PC by 4.
- R3: funct 0x24 writes the bitwise AND and 0x25 the bitwise OR. 0x2A writes 1 when R[rs] < R[rt] as two's-complement values and 0 otherwise.
- R4: Opcode 0x0D writes R[rt] = R[rs] OR {16'h0, imm[15:0]}. The immediate is zero-extended, so bit 15 does not spread upward.
- R5: Opcodes 0x23 (load) and 0x2B (store) use the byte address R[rs] + sign-extended imm[15:0], with word index address[DMEM_AW+1:2]. A load writes R[rt] with the stored word. A store writes R[rt] to memory and shows it on `st_addr`/`st_data` in that cycle.
- R6: Opcode 0x04 compares R[rs] and R[rt]. If they are equal the next PC is PC + 4 + (sign-extended imm << 2); otherwise it is PC + 4. It writes no register.
- R7: Opcode 0x02 sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00} and writes nothing.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and `wb_en` stays low.
- R9: Any other opcode, or an opcode-0x00 word with a funct outside the listed seven, writes no register and no memory. It only advances the PC by 4.
- R10: A register or memory word written at an edge is what the very next instruction reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Instruction-array write strobe |
| load_addr | input | IMEM_AW | Word index written by the load port |
| load_data | input | 32 | Instruction word written by the load port |
| pc | output | 32 | Current program counter (byte address) |
| instr | output | 32 | Instruction word fetched at `pc` |
| wb_en | output | 1 | Register write-back commits at the next edge |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | 32 | Value written back |
| st_en | output | 1 | Data store commits at the next edge |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store value |

## Verification
Two functions meet in one cycle in two ways. A register write-back lands at the same edge that makes the next instruction current, and that instruction reads the same register. A store to a word is followed at once by a load of the same word. The program sets up both: the load reads back the word stored in the previous cycle, and arithmetic consumes the register written just before it. A behavioural reference model in the bench predicts the write-back, store and next PC every cycle. Any stale value shows up as a mismatch tagged R10 as well as the instruction's own requirement.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int XLEN = 32;
   localparam int RAW  = 5;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_JMP  = 6'h02;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_ORI  = 6'h0D;
   localparam logic [5:0] OPC_LDW  = 6'h23;
   localparam logic [5:0] OPC_STW  = 6'h2B;

   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_ADDU  = 6'h21;
   localparam logic [5:0] FN_SUB   = 6'h22;
   localparam logic [5:0] FN_SUBU  = 6'h23;
   localparam logic [5:0] FN_AND   = 6'h24;
   localparam logic [5:0] FN_OR    = 6'h25;
   localparam logic [5:0] FN_SLT   = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_sel_e;

   typedef struct packed {
      logic     reg_write;
      logic     dst_is_rd;
      logic     use_imm;
      logic     zero_ext;
      logic     mem_read;
      logic     mem_write;
      logic     branch;
      logic     jump;
      alu_sel_e alu_sel;
   } ctl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctl_t       cs
);
   always_comb begin
      cs = '{reg_write: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, zero_ext: 1'b0,
             mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, jump: 1'b0,
             alu_sel: ALU_ADD};
      case (opcode)
         OPC_REG: begin
            cs.dst_is_rd = 1'b1;
            cs.reg_write = 1'b1;
            case (funct)
               FN_ADD, FN_ADDU: cs.alu_sel = ALU_ADD;
               FN_SUB, FN_SUBU: cs.alu_sel = ALU_SUB;
               FN_AND:          cs.alu_sel = ALU_AND;
               FN_OR:           cs.alu_sel = ALU_OR;
               FN_SLT:          cs.alu_sel = ALU_SLT;
               default:         cs.reg_write = 1'b0;
            endcase
         end
         OPC_ORI: begin
            cs.reg_write = 1'b1;
            cs.use_imm   = 1'b1;
            cs.zero_ext  = 1'b1;
            cs.alu_sel   = ALU_OR;
         end
         OPC_LDW: begin
            cs.reg_write = 1'b1;
            cs.use_imm   = 1'b1;
            cs.mem_read  = 1'b1;
         end
         OPC_STW: begin
            cs.use_imm   = 1'b1;
            cs.mem_write = 1'b1;
         end
         OPC_BEQ: begin
            cs.branch  = 1'b1;
            cs.alu_sel = ALU_SUB;
         end
         OPC_JMP: cs.jump = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_sel_e      sel,
   output logic [DW-1:0] y,
   output logic          eq
);
   initial begin
      if (DW < 2) $error("sc_alu: DW must be at least 2");
   end

   logic [DW-1:0] diff;
   assign diff = a - b;
   assign eq   = (diff == '0);

   always_comb begin
      case (sel)
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int DW       = 32,
   parameter int AW       = 5,
   parameter bit RST_REGS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra0,
   input  logic [AW-1:0] ra1,
   output logic [DW-1:0] rd0,
   output logic [DW-1:0] rd1,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd
);
   localparam int NREG = 1 << AW;

   initial begin
      if (AW < 1 || AW > 6) $error("sc_regfile: AW out of range");
   end

   logic [NREG*DW-1:0] flat;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign flat[i*DW +: DW] = '0;
      end else begin : g_live
         logic [DW-1:0] q;
         if (RST_REGS) begin : g_rst
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= '0;
               else if (we && wa == AW'(i))
                  q <= wd;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (we && wa == AW'(i))
                  q <= wd;
            end
         end
         assign flat[i*DW +: DW] = q;
      end
   end

   assign rd0 = flat[ra0*DW +: DW];
   assign rd1 = flat[ra1*DW +: DW];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_AW  = 6,
   parameter int DMEM_AW  = 6,
   parameter bit RST_REGS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_we,
   input  logic [IMEM_AW-1:0] load_addr,
   input  logic [31:0]        load_data,
   output logic [31:0]        pc,
   output logic [31:0]        instr,
   output logic               wb_en,
   output logic [4:0]         wb_reg,
   output logic [31:0]        wb_data,
   output logic               st_en,
   output logic [31:0]        st_addr,
   output logic [31:0]        st_data
);
   localparam int IMEM_WORDS = 1 << IMEM_AW;
   localparam int DMEM_WORDS = 1 << DMEM_AW;

   if (IMEM_AW < 1 || IMEM_AW > 12) begin : g_bad_iaw
      initial $error("sc_core: IMEM_AW out of range");
   end
   if (DMEM_AW < 1 || DMEM_AW > 12) begin : g_bad_daw
      initial $error("sc_core: DMEM_AW out of range");
   end

   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   logic [XLEN-1:0] pc_q, pc_nxt, pc_p4, br_tgt, jmp_tgt;
   logic [5:0]      f_op, f_fn;
   logic [RAW-1:0]  f_rs, f_rt, f_rd, dst;
   logic [15:0]     f_imm;
   logic [25:0]     f_tgt;
   logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, ld_val;
   logic            alu_eq;
   ctl_t            cs;

   always_ff @(posedge clk) begin
      if (load_we) imem[load_addr] <= load_data;
   end

   assign instr = imem[pc_q[IMEM_AW+1:2]];
   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_fn  = instr[5:0];
   assign f_imm = instr[15:0];
   assign f_tgt = instr[25:0];

   sc_ctrl u_ctrl (
      .opcode (f_op),
      .funct  (f_fn),
      .cs     (cs)
   );

   assign imm_ext = cs.zero_ext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};

   assign dst   = cs.dst_is_rd ? f_rd : f_rt;
   assign wb_en = rst_n && cs.reg_write && (dst != '0);

   sc_regfile #(
      .DW       (XLEN),
      .AW       (RAW),
      .RST_REGS (RST_REGS)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra0   (f_rs),
      .ra1   (f_rt),
      .rd0   (rs_val),
      .rd1   (rt_val),
      .we    (wb_en),
      .wa    (dst),
      .wd    (wb_data)
   );

   assign alu_b = cs.use_imm ? imm_ext : rt_val;

   sc_alu #(.DW(XLEN)) u_alu (
      .a   (rs_val),
      .b   (alu_b),
      .sel (cs.alu_sel),
      .y   (alu_y),
      .eq  (alu_eq)
   );

   assign ld_val  = dmem[alu_y[DMEM_AW+1:2]];
   assign wb_data = cs.mem_read ? ld_val : alu_y;
   assign wb_reg  = dst;

   assign st_en   = rst_n && cs.mem_write;
   assign st_addr = alu_y;
   assign st_data = rt_val;

   always_ff @(posedge clk) begin
      if (st_en) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
   end

   assign pc_p4   = pc_q + 32'd4;
   assign br_tgt  = pc_p4 + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_tgt = {pc_p4[31:28], f_tgt, 2'b00};

   always_comb begin
      if (cs.jump)
         pc_nxt = jmp_tgt;
      else if (cs.branch && alu_eq)
         pc_nxt = br_tgt;
      else
         pc_nxt = pc_p4;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_nxt;
   end

   assign pc = pc_q;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], imm_ext[XLEN-1:XLEN-2]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] pc,
   input logic [31:0] instr,
   input logic        wb_en,
   input logic [4:0]  wb_reg,
   input logic        st_en
);
   logic [5:0]  op;
   logic [31:0] step_pc, jmp_pc, br_pc;
   logic        known_op;

   assign op       = instr[31:26];
   assign step_pc  = pc + 32'd4;
   assign jmp_pc   = {step_pc[31:28], instr[25:0], 2'b00};
   assign br_pc    = step_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
   assign known_op = (op == 6'h00) || (op == 6'h02) || (op == 6'h04) ||
                     (op == 6'h0D) || (op == 6'h23) || (op == 6'h2B);

   a_r1_idle_in_reset: assert property (@(posedge clk)
      !rst_n |-> (!wb_en && !st_en));

   a_r8_no_r0_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_reg != 5'd0));

   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (op != 6'h04 && op != 6'h02) |=> (pc == $past(step_pc)));

   a_r7_jump_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'h02) |=> (pc == $past(jmp_pc)));

   a_r6_beq_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'h04) |=> (pc == $past(step_pc) || pc == $past(br_pc)));

   a_r6_beq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'h04) |-> (!wb_en && !st_en));

   a_r5_store_source: assert property (@(posedge clk) disable iff (!rst_n)
      st_en |-> (op == 6'h2B));

   a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !known_op |-> (!wb_en && !st_en));

   a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      pc[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pc     (pc),
   .instr  (instr),
   .wb_en  (wb_en),
   .wb_reg (wb_reg),
   .st_en  (st_en)
);

// File: tb/sc_core_test.sv
module sc_core_test;
   localparam int IAW = 6;
   localparam int NW  = 1 << IAW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load_we = 1'b0;
   logic [IAW-1:0] load_addr = '0;
   logic [31:0]    load_data = '0;
   logic [31:0]    pc, instr, wb_data, st_addr, st_data;
   logic           wb_en, st_en;
   logic [4:0]     wb_reg;

   always #4 clk = ~clk;

   sc_core #(.IMEM_AW(IAW), .DMEM_AW(6)) uut (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .pc(pc), .instr(instr), .wb_en(wb_en),
      .wb_reg(wb_reg), .wb_data(wb_data), .st_en(st_en),
      .st_addr(st_addr), .st_data(st_data)
   );

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   logic [31:0] prog [NW];
   logic [31:0] mreg [32];
   logic [31:0] mmem [64];
   logic [31:0] mpc;
   int          last_dst = -1;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // One cycle of the reference model: compare ports, then advance model state.
   task automatic step_model();
      logic [31:0] ins, a, b, sx, zx, res, addr, npc;
      logic [5:0]  op, fn;
      int          rs, rt, rd, dst;
      bit          e_wb, e_st, reads_last;
      string       tag;
      ins = prog[mpc[IAW+1:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      sx = {{16{ins[15]}}, ins[15:0]};
      zx = {16'h0, ins[15:0]};
      a = mreg[rs]; b = mreg[rt];
      e_wb = 0; e_st = 0; res = 0; addr = 0; dst = 0;
      npc = mpc + 4;
      tag = "R9";
      case (op)
         6'h00: begin
            dst = rd;
            case (fn)
               6'h20, 6'h21: begin res = a + b; e_wb = 1; tag = "R2"; end
               6'h22, 6'h23: begin res = a - b; e_wb = 1; tag = "R2"; end
               6'h24: begin res = a & b; e_wb = 1; tag = "R3"; end
               6'h25: begin res = a | b; e_wb = 1; tag = "R3"; end
               6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; e_wb = 1; tag = "R3"; end
               default: tag = "R9";
            endcase
         end
         6'h0D: begin dst = rt; res = a | zx; e_wb = 1; tag = "R4"; end
         6'h23: begin dst = rt; addr = a + sx; res = mmem[addr[7:2]]; e_wb = 1; tag = "R5"; end
         6'h2B: begin addr = a + sx; e_st = 1; tag = "R5"; end
         6'h04: begin tag = "R6"; if (a == b) npc = mpc + 4 + (sx << 2); end
         6'h02: begin tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00}; end
         default: tag = "R9";
      endcase
      if (e_wb && dst == 0) begin e_wb = 0; tag = "R8"; end
      reads_last = (last_dst > 0) && (rs == last_dst || rt == last_dst);

      chk(tag, "pc", pc, mpc);
      chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
      chk(tag, "st_en", {31'd0, st_en}, {31'd0, e_st});
      if (e_wb) begin
         chk(tag, "wb_reg", {27'd0, wb_reg}, 32'(dst));
         chk(tag, "wb_data", wb_data, res);
         if (reads_last) chk("R10", "wb_data after fresh write", wb_data, res);
      end
      if (e_st) begin
         chk(tag, "st_addr", st_addr, addr);
         chk(tag, "st_data", st_data, b);
         if (reads_last) chk("R10", "st_data after fresh write", st_data, b);
      end
      if (e_wb && dst != 0) mreg[dst] = res;
      if (e_st) mmem[addr[7:2]] = b;
      last_dst = e_wb ? dst : -1;
      mpc = npc;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NW; i++) prog[i] = 32'h0000_0000;
      for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
      for (int i = 0; i < 64; i++) mmem[i] = 32'h0;
      prog[0]  = enc_i(6'h0D, 0, 1, 16'h8000);   // R4 zero-extend
      prog[1]  = enc_r(0, 1, 2, 6'h22);          // R2 sub -> negative
      prog[2]  = enc_r(2, 1, 3, 6'h2A);          // R3 slt signed true
      prog[3]  = enc_r(1, 2, 4, 6'h2A);          // R3 slt signed false
      prog[4]  = enc_r(1, 2, 5, 6'h20);          // R2 add wrap to 0
      prog[5]  = enc_i(6'h0D, 0, 6, 16'h0040);
      prog[6]  = enc_i(6'h2B, 6, 1, 16'hFFFC);   // R5 store, negative offset
      prog[7]  = enc_i(6'h23, 6, 7, 16'hFFFC);   // R5/R10 load right after store
      prog[8]  = enc_r(2, 7, 8, 6'h24);          // R3 and
      prog[9]  = enc_r(2, 3, 9, 6'h25);          // R3 or
      prog[10] = enc_r(1, 1, 0, 6'h21);          // R8 write to r0 dropped
      prog[11] = enc_r(0, 3, 10, 6'h23);         // R8 r0 reads 0, subu wraps
      prog[12] = enc_i(6'h04, 7, 1, 16'h0002);   // R6 taken
      prog[13] = enc_i(6'h0D, 0, 11, 16'h1111);  // skipped
      prog[14] = enc_i(6'h0D, 0, 11, 16'h2222);  // skipped
      prog[15] = enc_i(6'h04, 1, 2, 16'h0005);   // R6 not taken
      prog[16] = {6'h3F, 26'h0000123};           // R9 unknown opcode
      prog[17] = enc_r(10, 10, 12, 6'h20);       // R2/R10
      prog[18] = {6'h02, 26'd20};                // R7 jump
      prog[19] = enc_i(6'h0D, 0, 14, 16'hDEAD);  // skipped
      prog[20] = enc_r(12, 12, 13, 6'h00);       // R9 unknown funct
      prog[21] = enc_i(6'h04, 0, 0, 16'hFFFF);   // R6 self loop

      for (int i = 0; i < NW; i++) begin
         @(negedge clk);
         load_we = 1'b1; load_addr = IAW'(i); load_data = prog[i];
      end
      @(negedge clk);
      load_we = 1'b0;
      @(negedge clk);
      chk("R1", "pc in reset", pc, 32'h0);
      chk("R1", "wb_en in reset", {31'd0, wb_en}, 32'h0);
      chk("R1", "st_en in reset", {31'd0, st_en}, 32'h0);
      rst_n = 1'b1;
      mpc = 32'h0;
      for (int c = 0; c < 30; c++) begin
         #1;
         step_model();
         @(negedge clk);
      end
      finish_run();
   end
endmodule